// File: doc/BRIEF.md
# DMA Transfer Count Unit with Reload

This unit keeps the transfer count of one DMA channel. Software loads a 16-bit count register and sets a reload enable bit. When the channel is activated, the count register value is copied into a separate working counter. If reload is enabled, the same value is also latched into a reload register. Each completed transfer unit, marked by a one-cycle pulse, lowers the working counter by one. The count register itself stays as software wrote it.

When the working counter reaches zero, the unit raises a sticky end-of-transfer flag and a one-cycle event pulse. What happens next depends on the reload enable bit:
- With reload disabled, the channel returns to idle.
- With reload enabled, the saved initial count is written back into the count register, and the channel parks in a hold state until a restart request runs it again.

A start value of zero is read as the full 2^16 range. Address generation, bus cycles and request arbitration belong to other blocks.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset, every register reads zero: count, reload value, working counter, reload enable and end-of-transfer flag. The channel is idle (`running`=0, `holding`=0).
- R2: A pulse on `activate` while the channel is not running copies the count register into the working counter and sets `running` on the same edge. A pulse on `activate` while running has no effect.
- R3: While running, each `unit_done` pulse lowers the working counter by exactly one. While not running, `unit_done` leaves the working counter unchanged.
- R4: Activating with a count register value of 0 runs 65536 transfer units before end of transfer.
- R5: On the edge where the working counter goes from 1 to 0, `eot_flag` is set. `eot_pulse` is high for exactly the one following cycle.
- R6: At terminal count with reload disabled, the channel goes idle and the count register keeps its value.
- R7: Activation with reload enabled copies the count register into the reload register. Activation with reload disabled leaves the reload register unchanged.
- R8: At terminal count with reload enabled, the reload register is written into the count register and the channel enters hold (`holding`=1). A `restart` pulse in hold loads the working counter from the count register and sets `running`.
- R9: A `restart` pulse outside the hold state has no effect.
- R10: A count write (`cnt_wr`) while running changes only the count register. The working counter keeps counting from its own value.
- R11: `eot_flag` stays set until a pulse on `eot_clr` clears it. If the flag is being set and cleared on the same edge, setting wins.
- R12: If a count write lands on the same edge as a terminal count with reload, the reload value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count register write data |
| cfg_wr | input | 1 | Reload enable write strobe |
| cfg_reload | input | 1 | Reload enable write data |
| activate | input | 1 | Activation pulse |
| restart | input | 1 | Restart request pulse (hold state only) |
| unit_done | input | 1 | One transfer unit completed |
| eot_clr | input | 1 | Clear pulse for the end-of-transfer flag |
| count_q | output | 16 | Count register |
| reload_q | output | 16 | Reload register |
| work_q | output | 16 | Working counter |
| reload_en_q | output | 1 | Reload enable bit |
| running | output | 1 | Channel is transferring |
| holding | output | 1 | Reloaded, waiting for restart |
| eot_flag | output | 1 | Sticky end-of-transfer flag |
| eot_pulse | output | 1 | One-cycle end-of-transfer event |

## Verification
A wrong working counter value shows on `work_q` one cycle after the faulty `unit_done` or load. It also moves the `eot_pulse` event earlier or later by whole transfer units.

A wrong reload capture stays hidden until terminal count. At that point it shows as a wrong `count_q` on the edge that enters hold, and again as a wrong `work_q` after the next restart.

A state machine fault shows within one cycle of terminal count: either `running` does not drop, or `holding` disagrees with the reload enable bit. The scoreboard ties each end-of-transfer event to the count register value and hold state expected at that moment.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int unsigned DXC_CNT_W = 16;

  typedef enum logic [1:0] {
    DXC_IDLE = 2'd0,
    DXC_RUN  = 2'd1,
    DXC_HOLD = 2'd2
  } dxc_state_e;
endpackage

// File: rtl/dxc_ctl.sv
module dxc_ctl
  import dxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic activate,
  input  logic restart,
  input  logic term_hit,
  input  logic reload_on,
  output logic load_work,
  output logic capture_rld,
  output logic run_st,
  output logic hold_st
);
  dxc_state_e state_q, state_d;
  logic       start_new, start_again;

  // Activation is honoured whenever the channel is not transferring.
  assign start_new   = activate & (state_q != DXC_RUN);
  // Restart only resumes a channel parked after a reload.
  assign start_again = restart & ~activate & (state_q == DXC_HOLD);
  assign load_work   = start_new | start_again;
  assign capture_rld = start_new & reload_on;
  assign run_st      = (state_q == DXC_RUN);
  assign hold_st     = (state_q == DXC_HOLD);

  always_comb begin
    state_d = state_q;
    case (state_q)
      DXC_RUN: begin
        if (term_hit) state_d = reload_on ? DXC_HOLD : DXC_IDLE;
      end
      DXC_IDLE, DXC_HOLD: begin
        if (load_work) state_d = DXC_RUN;
      end
      default: state_d = DXC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DXC_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dxc_down.sv
module dxc_down #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] work,
  output logic         term_hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] work_d;
  logic         work_en;

  // A start value of zero wraps through all ones, giving 2^W units.
  assign term_hit = dec & (work == ONE);
  assign work_en  = load | dec;

  always_comb begin
    work_d = work;
    if (load)     work_d = load_val;
    else if (dec) work_d = work - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work <= '0;
    else if (work_en) work <= work_d;
  end
endmodule

// File: rtl/dxc_regs.sv
module dxc_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cfg_wr,
  input  logic         cfg_reload,
  input  logic         capture_rld,
  input  logic         term_hit,
  input  logic         eot_clr,
  output logic [W-1:0] count_q,
  output logic [W-1:0] reload_q,
  output logic         reload_en_q,
  output logic         eot_flag,
  output logic         eot_pulse
);
  logic [W-1:0] count_d;
  logic         count_en, wb_reload, eot_d;

  // Reload write-back takes priority over a software write on the same edge.
  assign wb_reload = term_hit & reload_en_q;
  assign count_en  = wb_reload | cnt_wr;

  always_comb begin
    count_d = count_q;
    if (wb_reload)   count_d = reload_q;
    else if (cnt_wr) count_d = cnt_wdata;
  end

  // Setting the flag wins over clearing it.
  always_comb begin
    eot_d = eot_flag;
    if (term_hit)     eot_d = 1'b1;
    else if (eot_clr) eot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           reload_q <= '0;
    else if (capture_rld) reload_q <= count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reload_en_q <= 1'b0;
    else if (cfg_wr) reload_en_q <= cfg_reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eot_flag  <= 1'b0;
      eot_pulse <= 1'b0;
    end else begin
      eot_flag  <= eot_d;
      eot_pulse <= term_hit;
    end
  end
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
  import dxc_pkg::*;
#(
  parameter int unsigned CNT_W = DXC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cfg_wr,
  input  logic             cfg_reload,
  input  logic             activate,
  input  logic             restart,
  input  logic             unit_done,
  input  logic             eot_clr,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] work_q,
  output logic             reload_en_q,
  output logic             running,
  output logic             holding,
  output logic             eot_flag,
  output logic             eot_pulse
);
  logic load_work, capture_rld, term_hit, dec;

  // Transfer unit pulses count only while the channel is running.
  assign dec = unit_done & running;

  dxc_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .activate    (activate),
    .restart     (restart),
    .term_hit    (term_hit),
    .reload_on   (reload_en_q),
    .load_work   (load_work),
    .capture_rld (capture_rld),
    .run_st      (running),
    .hold_st     (holding)
  );

  dxc_down #(.W(CNT_W)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_work),
    .load_val (count_q),
    .dec      (dec),
    .work     (work_q),
    .term_hit (term_hit)
  );

  dxc_regs #(.W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (cnt_wdata),
    .cfg_wr      (cfg_wr),
    .cfg_reload  (cfg_reload),
    .capture_rld (capture_rld),
    .term_hit    (term_hit),
    .eot_clr     (eot_clr),
    .count_q     (count_q),
    .reload_q    (reload_q),
    .reload_en_q (reload_en_q),
    .eot_flag    (eot_flag),
    .eot_pulse   (eot_pulse)
  );
endmodule

// File: rtl/dxc_chk.sv
module dxc_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             activate,
  input logic             restart,
  input logic             unit_done,
  input logic             eot_clr,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] work_q,
  input logic             reload_en_q,
  input logic             running,
  input logic             holding,
  input logic             eot_flag,
  input logic             eot_pulse
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_act_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (activate && !running) |=> (running && work_q == $past(count_q)));

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && unit_done && work_q != ONE) |=> (work_q == $past(work_q) - ONE));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && unit_done && !activate && !restart) |=> $stable(work_q));

  p_eot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && unit_done && work_q == ONE) |=> (eot_flag && eot_pulse && work_q == '0));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && unit_done && work_q == ONE && !reload_en_q) |=> (!running && !holding));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && unit_done && work_q == ONE && reload_en_q)
      |=> (holding && count_q == $past(reload_q)));

  p_sw_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_wr && !unit_done) |=> ($stable(work_q) && count_q == $past(cnt_wdata)));

  p_eot_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_flag && !eot_clr) |=> eot_flag);

  p_mode_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({running, holding}));
endmodule

bind dma_xfer_count dxc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_wr      (cnt_wr),
  .cnt_wdata   (cnt_wdata),
  .activate    (activate),
  .restart     (restart),
  .unit_done   (unit_done),
  .eot_clr     (eot_clr),
  .count_q     (count_q),
  .reload_q    (reload_q),
  .work_q      (work_q),
  .reload_en_q (reload_en_q),
  .running     (running),
  .holding     (holding),
  .eot_flag    (eot_flag),
  .eot_pulse   (eot_pulse)
);

// File: tb/sim_dma_xfer_count.sv
module sim_dma_xfer_count;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_wr, cfg_wr, cfg_reload, activate, restart, unit_done, eot_clr;
  logic [15:0] cnt_wdata;
  logic [15:0] count_q, reload_q, work_q;
  logic        reload_en_q, running, holding, eot_flag, eot_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct packed {
    logic [15:0] count;
    logic        hold;
  } eot_item_t;
  eot_item_t exp_q[$];

  always #10 clk = ~clk;

  dma_xfer_count u0 (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cfg_wr(cfg_wr), .cfg_reload(cfg_reload), .activate(activate),
    .restart(restart), .unit_done(unit_done), .eot_clr(eot_clr),
    .count_q(count_q), .reload_q(reload_q), .work_q(work_q),
    .reload_en_q(reload_en_q), .running(running), .holding(holding),
    .eot_flag(eot_flag), .eot_pulse(eot_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(exp_q.size() == 0, "R5 pending end-of-transfer events", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: every end-of-transfer event is matched against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && eot_pulse) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected eot_pulse", 1, 0);
      end else begin
        eot_item_t it;
        it = exp_q.pop_front();
        chk(count_q == it.count, "R6/R8 count at eot", count_q, it.count);
        chk(holding == it.hold, "R6/R8 hold at eot", holding, it.hold);
        chk(!running, "R6/R8 not running at eot", running, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  task automatic write_cnt(input logic [15:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic write_cfg(input logic v);
    @(negedge clk); cfg_wr = 1'b1; cfg_reload = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_act();
    @(negedge clk); activate = 1'b1;
    @(negedge clk); activate = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); eot_clr = 1'b1;
    @(negedge clk); eot_clr = 1'b0;
  endtask

  task automatic units(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); unit_done = 1'b1;
    end
    @(negedge clk); unit_done = 1'b0;
  endtask

  task automatic expect_eot(input logic [15:0] c, input logic h);
    eot_item_t it;
    it.count = c;
    it.hold  = h;
    exp_q.push_back(it);
  endtask

  initial begin
    rst_n = 1'b0; cnt_wr = 0; cnt_wdata = '0; cfg_wr = 0; cfg_reload = 0;
    activate = 0; restart = 0; unit_done = 0; eot_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_q == 0 && reload_q == 0 && work_q == 0, "R1 registers zero",
        count_q | reload_q | work_q, 0);
    chk(!running && !holding && !eot_flag && !reload_en_q, "R1 idle state",
        {running, holding, eot_flag, reload_en_q}, 0);

    // Reload disabled run of three units.
    write_cnt(16'd3);
    pulse_act();
    chk(running && work_q == 3, "R2 activate loads working counter", work_q, 3);
    units(1);
    chk(work_q == 2, "R3 decrement by one", work_q, 2);
    write_cnt(16'd9);
    chk(count_q == 9 && work_q == 2, "R10 write while running", work_q, 2);
    pulse_act();
    chk(work_q == 2 && running, "R2 activate ignored while running", work_q, 2);
    expect_eot(16'd9, 1'b0);
    units(2);
    chk(work_q == 0 && eot_flag, "R5 flag set at terminal count", eot_flag, 1);
    @(negedge clk);
    chk(!eot_pulse, "R5 pulse lasts one cycle", eot_pulse, 0);
    chk(!running && !holding && count_q == 9, "R6 idle with count kept", count_q, 9);
    chk(reload_q == 0, "R7 no capture with reload disabled", reload_q, 0);
    units(2);
    chk(work_q == 0, "R3 unit_done ignored when idle", work_q, 0);
    chk(eot_flag, "R11 flag is sticky", eot_flag, 1);
    pulse_clr();
    chk(!eot_flag, "R11 clear by pulse", eot_flag, 0);
    pulse_restart();
    chk(!running && work_q == 0, "R9 restart ignored when idle", running, 0);

    // Reload enabled run of two units.
    write_cfg(1'b1);
    write_cnt(16'd2);
    pulse_act();
    chk(reload_q == 2 && work_q == 2, "R7 reload captured at activation", reload_q, 2);
    write_cnt(16'd7);
    expect_eot(16'd2, 1'b1);
    units(2);
    chk(holding && count_q == 2, "R8 count restored and holding", count_q, 2);
    units(1);
    chk(work_q == 0 && holding, "R3 unit_done ignored in hold", work_q, 0);
    pulse_clr();
    pulse_restart();
    chk(running && work_q == 2, "R8 restart reloads working counter", work_q, 2);
    pulse_restart();
    chk(work_q == 2, "R9 restart ignored while running", work_q, 2);
    units(1);
    // Final unit, a software write and a flag clear all land on one edge.
    expect_eot(16'd2, 1'b1);
    @(negedge clk); unit_done = 1'b1; cnt_wr = 1'b1; cnt_wdata = 16'h55; eot_clr = 1'b1;
    @(negedge clk); unit_done = 1'b0; cnt_wr = 1'b0; eot_clr = 1'b0;
    chk(count_q == 2, "R12 reload wins over write", count_q, 2);
    chk(eot_flag, "R11 set wins over clear", eot_flag, 1);

    // Zero start value, reload disabled: 65536 units.
    write_cfg(1'b0);
    write_cnt(16'd0);
    pulse_clr();
    pulse_act();
    chk(running && work_q == 0, "R4 zero start runs", running, 1);
    units(65535);
    chk(running && work_q == 1 && !eot_flag, "R4 no eot after 65535 units", work_q, 1);
    expect_eot(16'd0, 1'b0);
    units(1);
    chk(!running && eot_flag && work_q == 0, "R4 eot after 65536 units", eot_flag, 1);
    @(negedge clk);
    finish_run();
  end
endmodule